// File: doc/BRIEF.md
# Gated Countdown System Timer

This block is a single countdown timer for an event scheduler. Software programs it through a small register port with two registers: a control register at offset 0x40 and a count register at offset 0x44. The control register holds a run bit that gates all timer activity, an interrupt-enable bit, and a write-only acknowledge bit. Writing a tick count to the count register loads it and starts the countdown at once, with no separate start command. The count then drops by one on every clock in which the external tick enable is high.

When the count reaches zero the timer latches a pending flag and stays at zero; it does not reload. The interrupt line is asserted while the pending flag and the interrupt enable are both set. The run bit does more than start and stop the countdown. While it is clear, writes to the count register are ignored and the pending flag cannot be set or acknowledged. Writing zero to the control register therefore shuts the timer down completely.

A typical use is to set the run bit, write the tick count, and then set the run bit and the interrupt enable together. The service routine acknowledges by writing the run bit with the acknowledge bit set.

Top module: `sys_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0, the count register reads 0 and `irq` is low.
- R2: The control register is at offset 0x40. Bit 0 is the run bit and bit 1 is the interrupt enable; both read back as written. Bit 4 is the acknowledge bit and always reads 0. All other bits, and any offset other than 0x40 and 0x44, read 0.
- R3: While the run bit is set, a write to the count register at offset 0x44 loads the written value, and that value reads back in the next cycle.
- R4: While the run bit is clear, a write to the count register is ignored.
- R5: The count decreases by exactly one in each cycle where the run bit and `tick_en` are both high and the count is nonzero. In any other cycle the count holds, unless a load happens.
- R6: When the count goes from 1 to 0, the pending flag is set in the same cycle. The count then stays at 0 and does not reload.
- R7: `irq` is high exactly when the pending flag and the interrupt enable are both set. Setting the interrupt enable while the flag is pending raises `irq`.
- R8: A control write with bit 4 set clears the pending flag only if the run bit was already set before that write. A clear issued while the run bit is clear has no effect. If the count expires in the same cycle as a clear, the expiry wins.
- R9: Writing 0 to the control register stops the countdown, drops `irq`, and blocks later count writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick_en | input | 1 | Countdown step enable |
| irq | output | 1 | Interrupt request |

## Verification
Every register write takes effect at the clock edge on which the strobe is sampled. A write to the count register reads back one cycle later. A load of N with `tick_en` held high shows a count of 1 after N-1 more cycles and a count of 0 with `irq` high after N cycles, because expiry and the pending flag share that edge. The bench drives on falling edges and reads on the following falling edge. It sweeps the loaded value from 1 to 24 and samples at exactly those offsets, so an off-by-one in loading, stepping or flagging shows up. Gated stepping, acknowledge gating and shutdown are checked one cycle after each write, with `irq` used as the view of the pending flag.

// File: rtl/sct_pkg.sv
// Package: shared offsets and control-field positions for the countdown timer.
// Assumes byte offsets on an 8-bit address and a 32-bit register port.
package sct_pkg;
    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 32;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h44;
    localparam int BIT_RUN       = 0;
    localparam int BIT_IE        = 1;
    localparam int BIT_ACK       = 4;

    typedef struct packed {
        logic ie;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/sct_ctrl.sv
// Module: control register holding the run bit and interrupt enable.
// Assumes the write strobe is already qualified by the control offset.
module sct_ctrl
    import sct_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  logic  run_in,
    input  logic  ie_in,
    output ctrl_t ctrl_q
);
    // Purpose: capture the run and enable bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q.run <= run_in;
            ctrl_q.ie  <= ie_in;
        end
    end
endmodule

// File: rtl/sct_counter.sv
// Module: countdown register; loads on a gated write, steps down on tick, stops at zero.
// Assumes run_i is the registered run bit; a load takes priority over a step.
module sct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic load_ok;
    logic step_ok;

    // Purpose: qualify load and step with the run gate.
    always_comb begin
        load_ok  = load_req && run_i;
        step_ok  = run_i && tick_i && !load_ok && (cnt_q != '0);
        expire_o = step_ok && (cnt_q == ONE);
    end

    // Purpose: hold, load or decrement the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_ok) begin
            cnt_q <= load_val;
        end else if (step_ok) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/sct_irq.sv
// Module: pending-flag keeper; set on expiry, cleared by a gated acknowledge.
// Assumes expiry already implies the run bit; expiry outranks a clear.
module sct_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic expire_i,
    input  logic ack_req,
    output logic pend_q
);
    // Purpose: update the pending flag only while the run bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (run_i) begin
            if (expire_i) begin
                pend_q <= 1'b1;
            end else if (ack_req) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sys_countdown_timer.sv
// Module: top of the gated countdown timer; decodes the register port and forms irq.
// Assumes single-cycle writes and a combinational read path.
module sys_countdown_timer
    import sct_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              tick_en,
    output logic              irq
);
    localparam int CTRL_RD_W = 2;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             expire;
    logic             ctrl_wr;
    logic             count_wr;
    logic             ack_req;
    logic [CTRL_RD_W-1:0] ctrl_view;

    // Purpose: decode write strobes per register.
    always_comb begin
        ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
        count_wr = reg_wr && (reg_addr == OFS_COUNT);
        ack_req  = ctrl_wr && reg_wdata[BIT_ACK];
    end

    sct_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctrl_wr),
        .run_in (reg_wdata[BIT_RUN]),
        .ie_in  (reg_wdata[BIT_IE]),
        .ctrl_q (ctrl_q)
    );

    sct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl_q.run),
        .tick_i   (tick_en),
        .load_req (count_wr),
        .load_val (reg_wdata),
        .cnt_q    (cnt_q),
        .expire_o (expire)
    );

    sct_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl_q.run),
        .expire_i (expire),
        .ack_req  (ack_req),
        .pend_q   (pend_q)
    );

    // Purpose: place the control bits at their field positions for readback.
    always_comb begin
        ctrl_view          = '0;
        ctrl_view[BIT_RUN] = ctrl_q.run;
        ctrl_view[BIT_IE]  = ctrl_q.ie;
    end

    // Purpose: read multiplexer; unmapped offsets and the acknowledge bit read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL) begin
            reg_rdata[CTRL_RD_W-1:0] = ctrl_view;
        end else if (reg_addr == OFS_COUNT) begin
            reg_rdata = cnt_q;
        end
    end

    // Purpose: interrupt output from pending flag and enable.
    assign irq = pend_q && ctrl_q.ie;
endmodule

// File: rtl/sct_checker.sv
// Module: property checker for the countdown timer, bound into the top module.
// Assumes it observes the run/enable state, count, pending flag and strobes.
module sct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ie,
    input logic [CNT_W-1:0] cnt,
    input logic             pend,
    input logic             expire,
    input logic             count_wr,
    input logic             ack_req,
    input logic             tick_en,
    input logic             irq
);
    // R4 and R5: with the run bit clear, the count cannot move
    p_hold_when_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    // R5: a qualified step lowers the count by exactly one
    p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !count_wr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R6: at zero without a load the count stays at zero
    p_stay_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !(count_wr && run)) |=> (cnt == '0));

    // R6: reaching zero from one sets the pending flag
    p_expire_sets_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (pend && cnt == '0));

    // R7: irq can only rise on expiry or on the enable being set
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ie && ($past(expire) || !$past(ie))));

    // R8: a pending flag survives while the run bit is clear
    p_ack_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !run) |=> pend);

    // R8: a gated acknowledge without expiry clears the flag
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && run && !expire) |=> !pend);
endmodule

bind sys_countdown_timer sct_checker #(.CNT_W(CNT_W)) u_sct_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .ie       (ctrl_q.ie),
    .cnt      (cnt_q),
    .pend     (pend_q),
    .expire   (expire),
    .count_wr (count_wr),
    .ack_req  (ack_req),
    .tick_en  (tick_en),
    .irq      (irq)
);

// File: tb/test_sys_countdown_timer.sv
module test_sys_countdown_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL  = 8'h40;
    localparam logic [7:0] A_COUNT = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_countdown_timer i_sys_countdown_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // drive a write from one falling edge to the next
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        step(3);
        // R1: reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_COUNT, v); chk("R1 count", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rst_n = 1'b1;
        step(1);

        // R4: count write ignored while stopped
        wr(A_COUNT, 32'd5);
        rd(A_COUNT, v); chk("R4 stopped load", v, 0);

        // R2: control readback and field layout
        wr(A_CTRL, 32'h13);
        rd(A_CTRL, v); chk("R2 ack reads zero", v, 32'h3);
        rd(8'h48, v);  chk("R2 unmapped", v, 0);
        wr(A_CTRL, 32'hFFFF_FFED);
        rd(A_CTRL, v); chk("R2 other bits", v, 32'h1);
        wr(A_CTRL, 32'h3);

        // R3 R5 R6 R7: sweep of loaded counts
        tick_en = 1'b1;
        for (int n = 1; n <= 24; n++) begin
            wr(A_CTRL, 32'h13);
            chk("R8 ack clears", {31'd0, irq}, 0);
            wr(A_COUNT, n);
            rd(A_COUNT, v); chk("R3 load", v, n);
            step(n - 1);
            rd(A_COUNT, v); chk("R5 before zero", v, 1);
            chk("R7 irq low", {31'd0, irq}, 0);
            step(1);
            rd(A_COUNT, v); chk("R6 at zero", v, 0);
            chk("R6 irq set", {31'd0, irq}, 1);
            step(3);
            rd(A_COUNT, v); chk("R6 no reload", v, 0);
        end

        // R5: tick gating
        wr(A_CTRL, 32'h13);
        tick_en = 1'b0;
        wr(A_COUNT, 32'd10);
        step(4);
        rd(A_COUNT, v); chk("R5 no tick hold", v, 10);
        for (int i = 0; i < 8; i++) begin
            tick_en = (i % 2 == 0);
            step(1);
        end
        tick_en = 1'b0;
        rd(A_COUNT, v); chk("R5 half ticks", v, 6);

        // R8: acknowledge gated by run bit
        tick_en = 1'b1;
        step(6);
        chk("R8 expired", {31'd0, irq}, 1);
        wr(A_CTRL, 32'h02);
        chk("R8 pending kept", {31'd0, irq}, 1);
        wr(A_CTRL, 32'h12);
        chk("R8 ack ignored stopped", {31'd0, irq}, 1);
        wr(A_CTRL, 32'h03);
        chk("R8 still pending", {31'd0, irq}, 1);
        wr(A_CTRL, 32'h13);
        chk("R8 ack applied", {31'd0, irq}, 0);

        // R7: pending masked until enable set
        wr(A_CTRL, 32'h01);
        wr(A_COUNT, 32'd2);
        step(2);
        rd(A_COUNT, v); chk("R7 expired masked count", v, 0);
        chk("R7 masked", {31'd0, irq}, 0);
        wr(A_CTRL, 32'h03);
        chk("R7 enable raises", {31'd0, irq}, 1);

        // R9: full shutdown
        wr(A_CTRL, 32'h13);
        wr(A_COUNT, 32'd50);
        step(3);
        rd(A_COUNT, v); chk("R9 running", v, 47);
        wr(A_CTRL, 32'h0);
        rd(A_COUNT, v); chk("R9 stop edge", v, 46);
        rd(A_CTRL, v); chk("R9 ctrl zero", v, 0);
        chk("R9 irq low", {31'd0, irq}, 0);
        step(5);
        rd(A_COUNT, v); chk("R9 frozen", v, 46);
        wr(A_COUNT, 32'd9);
        rd(A_COUNT, v); chk("R9 load blocked", v, 46);

        finish_run();
    end
endmodule